// File: doc/BRIEF.md
# Single-Wire Bus Transceiver Mode Controller

This block is the digital mode controller of a low-speed single-wire bus transceiver. It keeps the transceiver in one of four operating modes: sleep, standby, normal-slope and low-slope. Four request pins ask for a mode (wake, normal, low and sleep). A change of mode never happens at once. Each possible destination mode has its own counter that measures how many consecutive clocks its request has been seen. The new mode is captured only on the clock where that counter overflows while the request is still present. With the 800 kHz reference clock (1.25 µs), leaving sleep takes 16 clocks (20 µs). Every other change takes 4 clocks (5 µs).

The controller produces the digital enables for the analog parts of the transceiver. These are the two slope-mode enables, the transmit-path enable, and the current-cell select lines for the edge-rate driver. The select lines are a thermometer decode of a 4-bit trim code. In sleep and standby the transmit path and all driver selects are off, so the bus does not follow the transmit data.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no request present, the mode output is 0 (sleep). All enables and cell selects are 0.
- R2: In sleep, only the wake request is acted on. After it has been sampled high on 16 consecutive rising edges, the mode becomes 1 (standby) on the 16th edge. Normal and low requests have no effect in sleep.
- R3: In sleep (mode 0) and standby (mode 1), tx_path_en, both slope enables and every cell select are 0.
- R4: Outside sleep, a normal request sampled on 4 consecutive edges changes the mode to 2 (normal slope) on the 4th edge. norm_slope_en is then 1 and low_slope_en is 0.
- R5: Outside sleep, a low request sampled on 4 consecutive edges changes the mode to 3 (low slope) on the 4th edge. low_slope_en is then 1 and norm_slope_en is 0.
- R6: Outside sleep, a sleep request sampled on 4 consecutive edges changes the mode to 0 on the 4th edge.
- R7: When several requests are high together outside sleep, sleep wins over low and low wins over normal. A request that loses the arbitration does not advance its count.
- R8: If a request drops before its count overflows, the mode is unchanged and the count restarts from zero. The next attempt needs the full number of clocks again.
- R9: A request for the mode already held has no effect, and neither does a wake request outside sleep.
- R10: In modes 2 and 3, cell_sel (15 bits) has its lowest N bits set and the rest clear, where N is the unsigned value of trim. Outside those modes cell_sel is 0.
- R11: tx_path_en is 1 exactly when the mode is 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 800 kHz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wake_req | input | 1 | Request to leave sleep for standby |
| norm_req | input | 1 | Request for normal-slope mode |
| low_req | input | 1 | Request for low-slope mode |
| sleep_req | input | 1 | Request for sleep mode |
| trim | input | 4 | Edge-rate trim code |
| mode_o | output | 2 | Current mode: 0 sleep, 1 standby, 2 normal, 3 low |
| norm_slope_en | output | 1 | Normal-slope driver enable |
| low_slope_en | output | 1 | Low-slope driver enable |
| tx_path_en | output | 1 | Transmit path enable |
| cell_sel | output | 15 | Thermometer select of driver current cells |

## Verification
The bench goes after the sleep lockout. A design that lets a normal or low request act in sleep would drive the bus without a wake, and one that counts the wake over 4 clocks instead of 16 would leave sleep 15 µs early. It drops requests one clock short of overflow and then repeats them. A design that keeps the partial count would then switch one attempt too early. It overlaps requests, including a low request that arrives while a normal count is running, which exposes wrong priority or a losing timer that keeps counting. It sweeps the trim code through 0, 15 and values in between, in and out of the slope modes, which catches an off-by-one in the thermometer decode and select lines that stay live in sleep.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'd0,
    MODE_STANDBY = 2'd1,
    MODE_NORMAL  = 2'd2,
    MODE_LOW     = 2'd3
  } mode_e;

  localparam int NUM_MODES = 4;
endpackage

// File: rtl/lin_rst_sync.sv
module lin_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/lin_mode_timer.sv
module lin_mode_timer #(
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic fire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_full;

  assign cnt_full = (cnt_q == {CNT_W{1'b1}});
  // overflow is gated by the live request: the flop only fires if it still stands
  assign fire = req & cnt_full;

  always_comb begin
    if (req) cnt_d = cnt_q + 1'b1;
    else     cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lin_trim_therm.sv
module lin_trim_therm #(
  parameter int TRIM_W = 4,
  parameter int CELLS  = (1 << TRIM_W) - 1
) (
  input  logic [TRIM_W-1:0] code,
  input  logic              enable,
  output logic [CELLS-1:0]  sel
);
  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    assign sel[i] = enable & ({1'b0, code} > (TRIM_W+1)'(i));
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int WAKE_CNT_W = 4,
  parameter int STEP_CNT_W = 2,
  parameter int TRIM_W     = 4,
  localparam int CELLS     = (1 << TRIM_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_req,
  input  logic              norm_req,
  input  logic              low_req,
  input  logic              sleep_req,
  input  logic [TRIM_W-1:0] trim,
  output logic [1:0]        mode_o,
  output logic              norm_slope_en,
  output logic              low_slope_en,
  output logic              tx_path_en,
  output logic [CELLS-1:0]  cell_sel
);
  logic                 srst_n;
  mode_e                mode_q, mode_d;
  mode_e                tgt;
  logic                 tgt_vld;
  logic [NUM_MODES-1:0] req_vec;
  logic [NUM_MODES-1:0] fire_vec;
  logic                 slope_on;

  lin_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // arbitration: sleep lockout, then sleep > low > normal
  always_comb begin
    tgt     = MODE_SLEEP;
    tgt_vld = 1'b0;
    if (mode_q == MODE_SLEEP) begin
      tgt     = MODE_STANDBY;
      tgt_vld = wake_req;
    end else if (sleep_req) begin
      tgt     = MODE_SLEEP;
      tgt_vld = 1'b1;
    end else if (low_req) begin
      tgt     = MODE_LOW;
      tgt_vld = 1'b1;
    end else if (norm_req) begin
      tgt     = MODE_NORMAL;
      tgt_vld = 1'b1;
    end
    if (tgt == mode_q) tgt_vld = 1'b0;
    req_vec = '0;
    if (tgt_vld) req_vec[tgt] = 1'b1;
  end

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_timer
    localparam int W = (g == int'(MODE_STANDBY)) ? WAKE_CNT_W : STEP_CNT_W;
    lin_mode_timer #(.CNT_W(W)) u_timer (
      .clk   (clk),
      .rst_n (srst_n),
      .req   (req_vec[g]),
      .fire  (fire_vec[g])
    );
  end

  always_comb begin
    mode_d = mode_q;
    for (int k = 0; k < NUM_MODES; k++) begin
      if (fire_vec[k]) mode_d = mode_e'(2'(k));
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)        mode_q <= MODE_SLEEP;
    else if (|fire_vec) mode_q <= mode_d;
  end

  assign slope_on      = (mode_q == MODE_NORMAL) | (mode_q == MODE_LOW);
  assign mode_o        = mode_q;
  assign norm_slope_en = (mode_q == MODE_NORMAL);
  assign low_slope_en  = (mode_q == MODE_LOW);
  assign tx_path_en    = slope_on;

  lin_trim_therm #(.TRIM_W(TRIM_W), .CELLS(CELLS)) u_therm (
    .code   (trim),
    .enable (slope_on),
    .sel    (cell_sel)
  );
endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk #(
  parameter int WAKE_CNT_W = 4,
  parameter int STEP_CNT_W = 2,
  parameter int TRIM_W     = 4,
  parameter int CELLS      = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wake_req,
  input logic              norm_req,
  input logic              sleep_req,
  input logic [TRIM_W-1:0] trim,
  input logic [1:0]        mode_o,
  input logic              tx_path_en,
  input logic [CELLS-1:0]  cell_sel
);
  localparam int WAKE_LIM = 1 << WAKE_CNT_W;
  localparam int STEP_LIM = 1 << STEP_CNT_W;

  int wake_run, norm_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_run <= 0;
      norm_run <= 0;
    end else begin
      wake_run <= wake_req ? ((wake_run < 1000) ? wake_run + 1 : wake_run) : 0;
      norm_run <= norm_req ? ((norm_run < 1000) ? norm_run + 1 : norm_run) : 0;
    end
  end

  AST_SLEEP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && !wake_req) |=> (mode_o == 2'd0)); // R2

  AST_WAKE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |=> (mode_o == 2'd0 || mode_o == 2'd1)); // R2

  AST_WAKE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && $past(mode_o) == 2'd0) |-> ($past(wake_run) >= WAKE_LIM - 1 && $past(wake_req))); // R2

  AST_NORM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && $past(mode_o) != 2'd2) |-> ($past(norm_run) >= STEP_LIM - 1 && $past(norm_req))); // R4

  AST_SLEEP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0 && sleep_req) |=> (mode_o == $past(mode_o) || mode_o == 2'd0)); // R7

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 || mode_o == 2'd1) |-> (!tx_path_en && cell_sel == '0)); // R3

  AST_CELL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_path_en |-> ($countones(cell_sel) == int'(trim))); // R10
endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk #(
  .WAKE_CNT_W (WAKE_CNT_W),
  .STEP_CNT_W (STEP_CNT_W),
  .TRIM_W     (TRIM_W),
  .CELLS      (CELLS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wake_req   (wake_req),
  .norm_req   (norm_req),
  .sleep_req  (sleep_req),
  .trim       (trim),
  .mode_o     (mode_o),
  .tx_path_en (tx_path_en),
  .cell_sel   (cell_sel)
);

// File: tb/lin_mode_ctrl_bench.sv
module lin_mode_ctrl_bench;
  localparam int CLK_PERIOD = 1250;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wake_req = 1'b0, norm_req = 1'b0, low_req = 1'b0, sleep_req = 1'b0;
  logic [3:0]  trim = 4'd0;
  logic [1:0]  mode_o;
  logic        norm_slope_en, low_slope_en, tx_path_en;
  logic [14:0] cell_sel;

  int    checks = 0, failures = 0;
  bit    done = 1'b0;
  string tag = "R1";

  int m_mode = 0;
  int run[4] = '{0, 0, 0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_mode_ctrl u_lin_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .norm_req(norm_req),
    .low_req(low_req), .sleep_req(sleep_req), .trim(trim), .mode_o(mode_o),
    .norm_slope_en(norm_slope_en), .low_slope_en(low_slope_en),
    .tx_path_en(tx_path_en), .cell_sel(cell_sel)
  );

  task automatic model_step();
    int t;
    int lim;
    if (!rst_n) begin
      m_mode = 0;
      foreach (run[k]) run[k] = 0;
      return;
    end
    t = -1;
    if (m_mode == 0) t = wake_req ? 1 : -1;
    else if (sleep_req) t = 0;
    else if (low_req) t = 3;
    else if (norm_req) t = 2;
    if (t == m_mode) t = -1;
    foreach (run[k]) run[k] = (t == k) ? run[k] + 1 : 0;
    if (t >= 0) begin
      lim = (t == 1) ? 16 : 4;
      if (run[t] == lim) begin
        m_mode = t;
        run[t] = 0;
      end
    end
  endtask

  task automatic compare();
    logic [14:0] exp_cells;
    bit slope;
    bit ok;
    slope = (m_mode == 2) || (m_mode == 3);
    exp_cells = slope ? 15'((16'd1 << trim) - 16'd1) : 15'd0;
    ok = (mode_o == 2'(m_mode)) && (norm_slope_en == (m_mode == 2)) &&
         (low_slope_en == (m_mode == 3)) && (tx_path_en == slope) &&
         (cell_sel == exp_cells);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: mode=%0d ne=%0b le=%0b tx=%0b cells=%h expected mode=%0d ne=%0b le=%0b tx=%0b cells=%h",
               tag, mode_o, norm_slope_en, low_slope_en, tx_path_en, cell_sel,
               m_mode, m_mode == 2, m_mode == 3, slope, exp_cells);
    end
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic set_req(input bit w, input bit n, input bit l, input bit s);
    wake_req = w; norm_req = n; low_req = l; sleep_req = s;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not end, expected end before 200000 clocks");
    finish_run();
  end

  initial begin
    // R1 reset and idle
    tag = "R1";
    run_cycles(5);
    rst_n = 1'b1;
    run_cycles(5);
    // R2 lockout: normal and low ignored in sleep
    tag = "R2"; trim = 4'd7;
    set_req(0, 1, 0, 0); run_cycles(8);
    set_req(0, 0, 1, 0); run_cycles(8);
    set_req(0, 1, 1, 0); run_cycles(6);
    // R8 short wake then restart
    tag = "R8";
    set_req(1, 0, 0, 0); run_cycles(15);
    set_req(0, 0, 0, 0); run_cycles(2);
    // R2 full wake to standby
    tag = "R2";
    set_req(1, 0, 0, 0); run_cycles(16);
    // R9 wake outside sleep, R3 standby quiet
    tag = "R9"; run_cycles(6);
    tag = "R3"; set_req(0, 0, 0, 0); trim = 4'd15; run_cycles(3);
    // R4 normal
    tag = "R4"; trim = 4'd5;
    set_req(0, 1, 0, 0); run_cycles(4);
    // R9 repeated request for current mode
    tag = "R9"; run_cycles(5);
    // R10 trim sweep in normal
    tag = "R10"; set_req(0, 0, 0, 0);
    trim = 4'd0;  run_cycles(1);
    trim = 4'd15; run_cycles(1);
    trim = 4'd9;  run_cycles(1);
    trim = 4'd1;  run_cycles(1);
    // R5 low
    tag = "R5"; trim = 4'd3;
    set_req(0, 0, 1, 0); run_cycles(4);
    tag = "R11"; set_req(0, 0, 0, 0); run_cycles(2);
    // R8 normal dropped before overflow
    tag = "R8";
    set_req(0, 1, 0, 0); run_cycles(3);
    set_req(0, 0, 0, 0); run_cycles(1);
    set_req(0, 1, 0, 0); run_cycles(3);
    set_req(0, 0, 0, 0); run_cycles(1);
    set_req(0, 1, 0, 0); run_cycles(4);
    // R7 all requests: sleep wins
    tag = "R7";
    set_req(0, 1, 1, 1); run_cycles(6);
    tag = "R3"; trim = 4'd12; set_req(0, 0, 0, 0); run_cycles(2);
    tag = "R2"; set_req(1, 0, 0, 0); run_cycles(16);
    // R7 low over normal, normal count interrupted by low
    tag = "R7";
    set_req(0, 1, 0, 0); run_cycles(2);
    set_req(0, 1, 1, 0); run_cycles(5);
    // R7 normal count must restart after low stops
    set_req(0, 1, 0, 0); run_cycles(2);
    set_req(0, 0, 0, 0); run_cycles(1);
    // R6 sleep from normal path
    tag = "R6";
    set_req(0, 0, 0, 1); run_cycles(3);
    set_req(0, 0, 0, 0); run_cycles(1);
    set_req(0, 0, 0, 1); run_cycles(5);
    tag = "R11"; set_req(0, 0, 1, 0); trim = 4'd15; run_cycles(6);
    // R1 reset in a slope mode
    tag = "R1"; set_req(1, 0, 0, 0); run_cycles(16);
    set_req(0, 1, 0, 0); run_cycles(5);
    set_req(0, 0, 0, 0);
    rst_n = 1'b0; run_cycles(3);
    rst_n = 1'b1; run_cycles(4);
    finish_run();
  end
endmodule